// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core

This block is a 32-bit processor core that retires one instruction on every clock edge. It runs a nine-instruction integer subset: word load and store, five register-to-register operations (add, subtract, bitwise and, bitwise or, signed set-less-than), a branch on register equality and an absolute jump. Instruction fetch and data access go through two separate memory ports. Both are read combinationally within the cycle. A store is committed by the memory at the next rising edge, when the write strobe is high.

Decoding is split into two levels. A main decoder turns the 6-bit opcode into datapath steering bits and a 2-bit operation class. A second, smaller decoder combines that class with the function field of register-format words to pick a 4-bit ALU operation code. The program counter is the only state that reset touches. The 32-entry register file keeps entry 0 fixed at zero.

Top module: `onecyc_cpu`

## Requirements
- R1: When `rst` is high at a rising edge, the program counter becomes 0. `imem_addr` always shows the program counter.
- R2: After an instruction that is neither a taken branch nor a jump, the program counter advances by 4.
- R3: A word with opcode 0x00 writes register rd (bits 15:11) with the result of rs (bits 25:21) combined with rt (bits 20:16). The function field (bits 5:0) selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or. Internally the ALU codes are AND 0000, OR 0001, add 0010, subtract 0110, set-less-than 0111 and NOR 1100.
- R4: Function 0x2A writes 1 to rd when rs is less than rt as a signed two's-complement value, and 0 otherwise.
- R5: Opcode 0x23 (load) drives `dmem_addr` = rs + sign-extended imm16 (bits 15:0), raises `dmem_rd`, and writes `dmem_rdata` into rt.
- R6: Opcode 0x2B (store) drives the same address, drives rt on `dmem_wdata` and raises `dmem_wr`. No other instruction raises `dmem_wr`, and a store never raises `dmem_rd`.
- R7: Opcode 0x04 sets the next PC to PC+4 + (sign-extended imm16 × 4) when rs equals rt, and to PC+4 otherwise. Negative offsets are included.
- R8: Opcode 0x02 sets the next PC to the top 4 bits of PC+4, then the 26-bit field (bits 25:0), then two zero bits.
- R9: Register 0 reads as zero, and writes to it are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the instruction being executed |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data byte address (the ALU result) |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data at `dmem_addr` |
| dmem_rd | output | 1 | High during a load |
| dmem_wr | output | 1 | High during a store; memory commits at the next edge |

## Verification
The bench goes after the following corner cases, each with a failure it would expose.

- **Signed compare.** Set-less-than is given operand pairs where the signed and unsigned orderings disagree. A core that compared unsigned would store the opposite bit.
- **Writes to register 0.** A write to register 0 is followed by a store of register 0. A core that let the write land would store a non-zero word.
- **Branch outcomes and offsets.** The program contains an untaken branch, a taken forward branch that skips two stores, and a taken branch with offset -1. A core that mis-scaled or failed to sign-extend the offset would fetch from the wrong address, and the skipped store slots would no longer read zero.
- **Jump target and load-after-store.** A jump is checked for its target concatenation, and a load reads back a word that the program itself stored. A core that wrote memory late or decoded the wrong opcode would return stale data.

// File: rtl/onecyc_pkg.sv
package onecyc_pkg;

  localparam int XW    = 32;
  localparam int NREG  = 32;
  localparam int RIDX  = $clog2(NREG);
  localparam int IMMW  = 16;
  localparam int JIDXW = 26;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_J     = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111,
    ALU_NOR = 4'b1100
  } alu_code_e;

  typedef enum logic [1:0] {
    AOP_MEM   = 2'b00,
    AOP_CMP   = 2'b01,
    AOP_FUNCT = 2'b10,
    AOP_RSVD  = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic    dst_rd;
    logic    branch;
    logic    jump;
    logic    mem_rd;
    logic    wb_mem;
    logic    reg_we;
    logic    mem_wr;
    logic    b_imm;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [XW-1:0] sext16(input logic [IMMW-1:0] v);
    return {{(XW-IMMW){v[IMMW-1]}}, v};
  endfunction

  function automatic logic [XW-1:0] branch_dest(input logic [XW-1:0] pc4,
                                                input logic [IMMW-1:0] off);
    return pc4 + (sext16(off) << 2);
  endfunction

  function automatic logic [XW-1:0] jump_dest(input logic [XW-1:0] pc4,
                                              input logic [JIDXW-1:0] idx);
    return {pc4[XW-1:JIDXW+2], idx, 2'b00};
  endfunction

  function automatic logic [XW-1:0] alu_eval(input alu_code_e code,
                                             input logic [XW-1:0] a,
                                             input logic [XW-1:0] b);
    logic [XW-1:0] y;
    case (code)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(XW-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_NOR: y = ~(a | b);
      default: y = '0;
    endcase
    return y;
  endfunction

endpackage

// File: rtl/onecyc_regfile.sv
module onecyc_regfile
  import onecyc_pkg::*;
#(
  parameter int W = XW,
  parameter int N = NREG,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);

  logic [W-1:0] regs [N];
  logic         wr_live;

  assign wr_live = we && (wa != '0);

  always_ff @(posedge clk) begin
    if (wr_live) regs[wa] <= wd;
  end

  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

  // R3: an accepted write is held by the addressed entry after the edge
  p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
    wr_live |=> (regs[$past(wa)] == $past(wd)))
    else $error("p_write_lands_r3");

endmodule

// File: rtl/onecyc_main_dec.sv
module onecyc_main_dec
  import onecyc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctl
);

  always_comb begin
    ctl = '0;
    ctl.alu_op = AOP_MEM;
    case (opcode)
      OP_RTYPE: begin
        ctl.dst_rd = 1'b1;
        ctl.reg_we = 1'b1;
        ctl.alu_op = AOP_FUNCT;
      end
      OP_LW: begin
        ctl.b_imm  = 1'b1;
        ctl.wb_mem = 1'b1;
        ctl.reg_we = 1'b1;
        ctl.mem_rd = 1'b1;
      end
      OP_SW: begin
        ctl.b_imm  = 1'b1;
        ctl.mem_wr = 1'b1;
      end
      OP_BEQ: begin
        ctl.branch = 1'b1;
        ctl.alu_op = AOP_CMP;
      end
      OP_J: ctl.jump = 1'b1;
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/onecyc_alu_dec.sv
module onecyc_alu_dec
  import onecyc_pkg::*;
(
  input  alu_op_e    alu_op,
  input  logic [5:0] funct,
  output alu_code_e  code
);

  always_comb begin
    case (alu_op)
      AOP_MEM: code = ALU_ADD;
      AOP_CMP: code = ALU_SUB;
      AOP_FUNCT: begin
        case (funct)
          FN_ADD:  code = ALU_ADD;
          FN_SUB:  code = ALU_SUB;
          FN_AND:  code = ALU_AND;
          FN_OR:   code = ALU_OR;
          FN_SLT:  code = ALU_SLT;
          default: code = ALU_NOR;
        endcase
      end
      default: code = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/onecyc_alu.sv
module onecyc_alu
  import onecyc_pkg::*;
#(
  parameter int W = XW
) (
  input  logic      clk,
  input  logic      rst,
  input  alu_code_e code,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic      zero
);

  assign y    = alu_eval(code, a, b);
  assign zero = (y == '0);

  // R4: set-less-than only ever yields 0 or 1
  p_slt_bit_r4: assert property (@(posedge clk) disable iff (rst)
    (code == ALU_SLT) |-> (y[W-1:1] == '0))
    else $error("p_slt_bit_r4");

endmodule

// File: rtl/onecyc_cpu.sv
module onecyc_cpu
  import onecyc_pkg::*;
#(
  parameter logic [XW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst,
  output logic [XW-1:0] imem_addr,
  input  logic [XW-1:0] imem_rdata,
  output logic [XW-1:0] dmem_addr,
  output logic [XW-1:0] dmem_wdata,
  input  logic [XW-1:0] dmem_rdata,
  output logic          dmem_rd,
  output logic          dmem_wr
);

  logic [XW-1:0]   pc, pc4, pc_nxt, br_tgt, jp_tgt;
  logic [5:0]      f_op, f_fn;
  logic [RIDX-1:0] f_rs, f_rt, f_rd, wr_idx;
  logic [IMMW-1:0] f_imm;
  logic [JIDXW-1:0] f_jidx;
  logic [XW-1:0]   rs_val, rt_val, imm_sx, alu_b, alu_y, wb_val;
  logic            alu_zero, take_br;
  ctrl_t           ctl;
  alu_code_e       acode;

  assign f_op   = imem_rdata[31:26];
  assign f_rs   = imem_rdata[25:21];
  assign f_rt   = imem_rdata[20:16];
  assign f_rd   = imem_rdata[15:11];
  assign f_fn   = imem_rdata[5:0];
  assign f_imm  = imem_rdata[15:0];
  assign f_jidx = imem_rdata[25:0];

  onecyc_main_dec u_main (.opcode(f_op), .ctl(ctl));

  onecyc_alu_dec u_adec (.alu_op(ctl.alu_op), .funct(f_fn), .code(acode));

  assign wr_idx = ctl.dst_rd ? f_rd : f_rt;
  assign wb_val = ctl.wb_mem ? dmem_rdata : alu_y;

  onecyc_regfile #(.W(XW), .N(NREG)) u_rf (
    .clk(clk), .rst(rst),
    .ra_a(f_rs), .ra_b(f_rt), .rd_a(rs_val), .rd_b(rt_val),
    .we(ctl.reg_we), .wa(wr_idx), .wd(wb_val)
  );

  assign imm_sx = sext16(f_imm);
  assign alu_b  = ctl.b_imm ? imm_sx : rt_val;

  onecyc_alu #(.W(XW)) u_alu (
    .clk(clk), .rst(rst), .code(acode),
    .a(rs_val), .b(alu_b), .y(alu_y), .zero(alu_zero)
  );

  assign pc4     = pc + XW'(4);
  assign br_tgt  = branch_dest(pc4, f_imm);
  assign jp_tgt  = jump_dest(pc4, f_jidx);
  assign take_br = ctl.branch & alu_zero;

  always_comb begin
    if (ctl.jump)   pc_nxt = jp_tgt;
    else if (take_br) pc_nxt = br_tgt;
    else            pc_nxt = pc4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_PC;
    else     pc <= pc_nxt;
  end

  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_rd    = ctl.mem_rd;
  assign dmem_wr    = ctl.mem_wr;

  // R1: reset lands the program counter on the reset address
  p_reset_pc_r1: assert property (@(posedge clk)
    rst |=> (imem_addr == RESET_PC))
    else $error("p_reset_pc_r1");

  // R2: plain instructions step by one word
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!take_br && !ctl.jump) |=> (pc == $past(pc) + XW'(4)))
    else $error("p_step_r2");

  // R7: taken branch adds the scaled offset to the incremented PC
  p_branch_r7: assert property (@(posedge clk) disable iff (rst)
    take_br |=> (pc == $past(pc) + XW'(4) + {$past(imm_sx[XW-3:0]), 2'b00}))
    else $error("p_branch_r7");

  // R8: jump keeps the top nibble of PC+4
  p_jump_r8: assert property (@(posedge clk) disable iff (rst)
    ctl.jump |=> (pc[XW-1:28] == $past(pc4[XW-1:28]) && pc[1:0] == 2'b00))
    else $error("p_jump_r8");

  // R6: load and store strobes are never high together
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(dmem_rd && dmem_wr))
    else $error("p_strobe_excl_r6");

  // R9: register file read of index 0 is zero
  p_zero_reg_r9: assert property (@(posedge clk) disable iff (rst)
    (f_rs == '0) |-> (rs_val == '0))
    else $error("p_zero_reg_r9");

endmodule

// File: tb/onecyc_cpu_tb_top.sv
`timescale 1ns/1ps
module onecyc_cpu_tb_top;

  localparam int MEMW  = 64;
  localparam int STEPS = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_rd, dmem_wr;

  logic [31:0] prog [MEMW];
  logic [31:0] dmem [MEMW];
  logic [31:0] mdm  [MEMW];
  logic [31:0] mreg [32];

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [31:0] pc;
    logic [1:0]  pc_why;   // 0 reset, 1 step, 2 branch, 3 jump
    logic        st;
    logic        ld;
    logic [31:0] addr;
    logic [31:0] data;
  } exp_t;

  exp_t sb_q [$];

  always #10 clk = ~clk;

  onecyc_cpu dut_i (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .dmem_rd(dmem_rd), .dmem_wr(dmem_wr)
  );

  assign imem_rdata = prog[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_wr) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] r_op(input logic [5:0] fn, input int d, input int s, input int t);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, fn};
  endfunction

  function automatic logic [31:0] i_op(input logic [5:0] op, input int s, input int t, input int imm);
    return {op, 5'(s), 5'(t), 16'(imm)};
  endfunction

  function automatic string data_req(input int idx);
    case (idx)
      6, 8, 10, 12: return "R3";
      14, 16:       return "R4";
      18:           return "R9";
      24:           return "R5";
      default:      return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference model: steps the program and pushes one expected item per cycle
  task automatic drive_model(input int steps);
    logic [31:0] pc = 32'd0;
    logic [1:0]  why = 2'd0;
    for (int k = 0; k < steps; k++) begin
      logic [31:0] w, a, b, ea, nxt;
      int op, fn, s, t, d;
      exp_t it;
      w  = prog[pc[7:2]];
      op = int'(w[31:26]); s = int'(w[25:21]); t = int'(w[20:16]);
      d  = int'(w[15:11]); fn = int'(w[5:0]);
      a  = (s == 0) ? 32'd0 : mreg[s];
      b  = (t == 0) ? 32'd0 : mreg[t];
      ea = a + 32'($signed(w[15:0]));
      nxt = pc + 32'd4;
      it = '0; it.pc = pc; it.pc_why = why;
      why = 2'd1;
      if (op == 0) begin
        logic [31:0] r;
        if (fn == 32) r = a + b;
        else if (fn == 34) r = a - b;
        else if (fn == 36) r = a & b;
        else if (fn == 37) r = a | b;
        else if (fn == 42) r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        else r = ~(a | b);
        if (d != 0) mreg[d] = r;
      end else if (op == 35) begin
        it.ld = 1'b1; it.addr = ea;
        if (t != 0) mreg[t] = mdm[ea[7:2]];
      end else if (op == 43) begin
        it.st = 1'b1; it.addr = ea; it.data = b;
        mdm[ea[7:2]] = b;
      end else if (op == 4) begin
        if (a == b) begin
          nxt = nxt + 32'($signed(w[15:0])) * 4;
          why = 2'd2;
        end
      end else if (op == 2) begin
        nxt = {nxt[31:28], w[25:0], 2'b00};
        why = 2'd3;
      end
      sb_q.push_back(it);
      pc = nxt;
    end
  endtask

  task automatic load_program();
    for (int i = 0; i < MEMW; i++) begin prog[i] = 32'd0; dmem[i] = 32'd0; end
    for (int i = 0; i < 32; i++) mreg[i] = 32'd0;
    dmem[0] = 32'h0000_0007;
    dmem[1] = 32'hFFFF_FFFB;
    dmem[2] = 32'h0F0F_00FF;
    dmem[3] = 32'h00FF_0F0F;
    dmem[4] = 32'h0000_0040;
    prog[0]  = i_op(6'h23, 0, 1, 0);
    prog[1]  = i_op(6'h23, 0, 2, 4);
    prog[2]  = i_op(6'h23, 0, 3, 8);
    prog[3]  = i_op(6'h23, 0, 4, 12);
    prog[4]  = i_op(6'h23, 0, 5, 16);
    prog[5]  = r_op(6'h20, 6, 1, 2);
    prog[6]  = i_op(6'h2B, 5, 6, 0);
    prog[7]  = r_op(6'h22, 7, 1, 2);
    prog[8]  = i_op(6'h2B, 5, 7, 4);
    prog[9]  = r_op(6'h24, 8, 3, 4);
    prog[10] = i_op(6'h2B, 5, 8, 8);
    prog[11] = r_op(6'h25, 9, 3, 4);
    prog[12] = i_op(6'h2B, 5, 9, 12);
    prog[13] = r_op(6'h2A, 10, 2, 1);
    prog[14] = i_op(6'h2B, 5, 10, 16);
    prog[15] = r_op(6'h2A, 11, 1, 2);
    prog[16] = i_op(6'h2B, 5, 11, 20);
    prog[17] = r_op(6'h20, 0, 1, 1);
    prog[18] = i_op(6'h2B, 5, 0, 24);
    prog[19] = i_op(6'h04, 1, 2, 5);
    prog[20] = i_op(6'h04, 1, 1, 2);
    prog[21] = i_op(6'h2B, 5, 1, 28);
    prog[22] = i_op(6'h2B, 5, 1, 28);
    prog[23] = i_op(6'h23, 0, 12, 64);
    prog[24] = i_op(6'h2B, 5, 12, 32);
    prog[25] = {6'h02, 26'd27};
    prog[26] = i_op(6'h2B, 5, 1, 36);
    prog[27] = i_op(6'h04, 0, 0, -1);
    for (int i = 0; i < MEMW; i++) mdm[i] = dmem[i];
  endtask

  // Monitor: pops one expected item per cycle and compares at the ports
  task automatic monitor();
    while (sb_q.size() > 0) begin
      exp_t it;
      string pr;
      it = sb_q.pop_front();
      case (it.pc_why)
        2'd0: pr = "R1";
        2'd2: pr = "R7";
        2'd3: pr = "R8";
        default: pr = "R2";
      endcase
      chk(pr, "pc", imem_addr, it.pc);
      if (imem_addr === it.pc) begin
        chk("R6", "store strobe", {31'd0, dmem_wr}, {31'd0, it.st});
        if (it.st) begin
          chk("R6", "store addr", dmem_addr, it.addr);
          chk(data_req(int'(it.pc[7:2])), "store data", dmem_wdata, it.data);
        end
        if (it.ld) begin
          chk("R5", "load strobe", {31'd0, dmem_rd}, 32'd1);
          chk("R5", "load addr", dmem_addr, it.addr);
        end
      end
      @(negedge clk); #1;
    end
  endtask

  initial begin
    load_program();
    drive_model(STEPS);
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "pc after reset", imem_addr, 32'd0);
    rst = 1'b0;
    monitor();
    // skipped slots stay untouched; all of memory matches the model
    chk("R7", "skipped store slot", dmem[23], 32'd0);
    chk("R8", "jumped-over store slot", dmem[25], 32'd0);
    chk("R9", "r0 store", dmem[22], 32'd0);
    for (int i = 0; i < MEMW; i++) chk("R6", "memory image", dmem[i], mdm[i]);
    rst = 1'b1;
    @(negedge clk); #1;
    chk("R1", "pc after mid-run reset", imem_addr, 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule